// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a processor-style write port and the control of a byte-wide flash array. It watches each accepted bus write (address and data) and walks a small state machine through the two-write unlock prefix and the command byte that follows. When a complete, well-formed sequence arrives it raises a one-cycle start pulse for byte program, chip erase, sector erase or boot-lockout enable, and it captures the target address and data of that final write for the array controller.

The same sequences also switch an identifier read-out mode on and off. While that mode is active, a small read port returns a maker byte, a device byte that depends on whether the boot region sits at the top or bottom of the array, a second device byte, and the current lockout flag. An external busy input freezes the decoder while a long erase runs, so stray writes during that time change nothing.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the block is in read-array mode: no start pulse, identifier mode off, lockout flag clear, `id_data` equal to 8'h00.
- R2: Only address bits 10:0 are compared against the key locations; bit 11 and all higher bits are ignored, so 18'h3F555 matches the first key and 18'h002AA matches the second key (11'h2AA).
- R3: The writes AA at 555, 55 at 2AA, A0 at 555 arm a program; the next accepted write of any address and data makes `prog_start` high for exactly the following cycle, with `op_addr` and `op_data` holding that write.
- R4: The writes AA/555, 55/2AA, 80/555, AA/555, 55/2AA, 10/555 make `chip_erase_start` high for the cycle after the sixth write.
- R5: The same prefix followed by 30 written to any address makes `sector_erase_start` high for the cycle after that write, with `op_addr` equal to the full address of that sixth write.
- R6: The same prefix followed by 40 at 555 pulses `lock_set` and sets `boot_locked`, which stays 1 through all later commands and is cleared only by reset.
- R7: After AA/555, 55/2AA, 90/555 `id_mode` is 1 from the following cycle; in that mode `id_data` for `rd_sel` 0,1,2,3 is 8'h1F, 8'h07 (8'h08 when the boot region is at the top), {7'b0, boot_locked} and 8'h0F; outside that mode `id_data` is 8'h00.
- R8: Identifier mode is left either by AA/555, 55/2AA, F0/555 or by one write of F0 to any address while the state machine is idle; F0 outside identifier mode has no effect.
- R9: A write that does not match the expected address and data at any step returns the state machine to idle and issues no command, so a later command byte needs a fresh unlock.
- R10: A write presented while `busy` is high is ignored: it issues no command and leaves the sequence position unchanged.
- R11: At most one start pulse is high in any cycle, and no start pulse lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe per bus write |
| wr_addr | input | ADDR_W (18) | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | High while an erase runs; writes are ignored |
| rd_sel | input | 2 | Identifier location selector |
| prog_start | output | 1 | Byte program start pulse |
| chip_erase_start | output | 1 | Chip erase start pulse |
| sector_erase_start | output | 1 | Sector erase start pulse |
| lock_set | output | 1 | Boot-lockout enable pulse |
| op_addr | output | ADDR_W (18) | Address of the command's final write |
| op_data | output | 8 | Data of the command's final write |
| id_mode | output | 1 | Identifier mode active |
| boot_locked | output | 1 | Sticky boot-lockout flag |
| id_data | output | 8 | Identifier read data |

## Verification
Two functions can meet in one cycle: the sixth write of the lockout sequence can be accepted in the very cycle an identifier read of location 2 is in progress. The bench holds `rd_sel` at 2 while in identifier mode, presents the final 40/555 write, and samples `id_data` before the clock edge (expecting the old flag, 8'h00) and after it (expecting 8'h01 together with the `lock_set` pulse). A second overlap, a sequence-completing write arriving while `busy` is high, is judged by the absence of any start pulse and by the sequence continuing from the same step once `busy` falls.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int CMP_W  = 11;
  localparam int DATA_W = 8;

  localparam logic [CMP_W-1:0]  KEY_LO = 11'h555;
  localparam logic [CMP_W-1:0]  KEY_HI = 11'h2AA;

  localparam logic [DATA_W-1:0] D_UNLK_A = 8'hAA;
  localparam logic [DATA_W-1:0] D_UNLK_B = 8'h55;
  localparam logic [DATA_W-1:0] D_PROG   = 8'hA0;
  localparam logic [DATA_W-1:0] D_EXT    = 8'h80;
  localparam logic [DATA_W-1:0] D_IDON   = 8'h90;
  localparam logic [DATA_W-1:0] D_IDOFF  = 8'hF0;
  localparam logic [DATA_W-1:0] D_CHIP   = 8'h10;
  localparam logic [DATA_W-1:0] D_SECT   = 8'h30;
  localparam logic [DATA_W-1:0] D_LOCK   = 8'h40;

  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG, ST_EXT3, ST_EXT4, ST_EXT5
  } seq_st_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_PROG, OP_CHIP, OP_SECT, OP_LOCK, OP_ID_ON, OP_ID_OFF
  } op_t;

  typedef struct packed {
    seq_st_t nxt;
    op_t     op;
  } step_t;

  function automatic logic at_key(input logic [CMP_W-1:0] a,
                                  input logic [CMP_W-1:0] key);
    return a == key;
  endfunction

  // One step of the command walk: where the next write lands and what it issues.
  function automatic step_t decode_step(input seq_st_t st,
                                        input logic [CMP_W-1:0] a,
                                        input logic [DATA_W-1:0] d);
    step_t r;
    r.nxt = ST_IDLE;
    r.op  = OP_NONE;
    case (st)
      ST_IDLE: begin
        if (d == D_IDOFF)                            r.op  = OP_ID_OFF;
        else if (d == D_UNLK_A && at_key(a, KEY_LO)) r.nxt = ST_UNL1;
      end
      ST_UNL1: if (d == D_UNLK_B && at_key(a, KEY_HI)) r.nxt = ST_UNL2;
      ST_UNL2: begin
        if (at_key(a, KEY_LO)) begin
          case (d)
            D_PROG:  r.nxt = ST_PROG;
            D_EXT:   r.nxt = ST_EXT3;
            D_IDON:  r.op  = OP_ID_ON;
            D_IDOFF: r.op  = OP_ID_OFF;
            default: r.nxt = ST_IDLE;
          endcase
        end
      end
      ST_PROG: r.op = OP_PROG;
      ST_EXT3: if (d == D_UNLK_A && at_key(a, KEY_LO)) r.nxt = ST_EXT4;
      ST_EXT4: if (d == D_UNLK_B && at_key(a, KEY_HI)) r.nxt = ST_EXT5;
      ST_EXT5: begin
        if (d == D_SECT)                           r.op = OP_SECT;
        else if (d == D_CHIP && at_key(a, KEY_LO)) r.op = OP_CHIP;
        else if (d == D_LOCK && at_key(a, KEY_LO)) r.op = OP_LOCK;
      end
      default: r.nxt = ST_IDLE;
    endcase
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] id_value(input logic [1:0] sel,
                                                 input logic top_boot,
                                                 input logic locked);
    case (sel)
      2'd0:    return 8'h1F;
      2'd1:    return top_boot ? 8'h08 : 8'h07;
      2'd2:    return {7'b0, locked};
      default: return 8'h0F;
    endcase
  endfunction

endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              busy,
  input  logic [CMP_W-1:0]  key_addr,
  input  logic [DATA_W-1:0] wr_data,
  output seq_st_t           state,
  output op_t               op,
  output logic              accept
);

  step_t step;

  assign accept = wr_en & ~busy;

  always_comb step = decode_step(state, key_addr, wr_data);

  assign op = accept ? step.op : OP_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n)      state <= ST_IDLE;
    else if (accept) state <= step.nxt;
  end

  // R3: the program-armed step is reached only from the second unlock step
  a_r3_prog_after_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG && $past(state) != ST_PROG) |-> $past(state) == ST_UNL2);

  // R4: the sixth-cycle step is reached only through the second unlock pair
  a_r4_ext5_after_ext4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXT5 && $past(state) != ST_EXT5) |-> $past(state) == ST_EXT4);

  // R10: a write blocked by busy leaves the sequence position untouched
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> $stable(state));

endmodule

// File: rtl/flash_op_issue.sv
module flash_op_issue
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_t               op,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              prog_start,
  output logic              chip_start,
  output logic              sect_start,
  output logic              lock_start,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);

  logic array_op;
  assign array_op = (op == OP_PROG) || (op == OP_CHIP) ||
                    (op == OP_SECT) || (op == OP_LOCK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_start <= 1'b0;
      chip_start <= 1'b0;
      sect_start <= 1'b0;
      lock_start <= 1'b0;
      op_addr    <= '0;
      op_data    <= '0;
    end else begin
      prog_start <= (op == OP_PROG);
      chip_start <= (op == OP_CHIP);
      sect_start <= (op == OP_SECT);
      lock_start <= (op == OP_LOCK);
      if (array_op) begin
        op_addr <= wr_addr;
        op_data <= wr_data;
      end
    end
  end

  // R11: never two start pulses at once
  a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, chip_start, sect_start, lock_start}));

  // R11: each pulse lasts a single cycle
  a_r11_prog_single: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);
  a_r11_erase_single: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_start || sect_start) |=> !(chip_start || sect_start));

endmodule

// File: rtl/flash_id_ctl.sv
module flash_id_ctl
  import flash_cmd_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_t               op,
  input  logic [1:0]        rd_sel,
  output logic              id_mode,
  output logic              locked,
  output logic [DATA_W-1:0] id_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_mode <= 1'b0;
      locked  <= 1'b0;
    end else begin
      if (op == OP_ID_ON)       id_mode <= 1'b1;
      else if (op == OP_ID_OFF) id_mode <= 1'b0;
      if (op == OP_LOCK)        locked  <= 1'b1;
    end
  end

  assign id_data = id_mode ? id_value(rd_sel, TOP_BOOT, locked) : '0;

  // R6: the lockout flag is sticky
  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R6: the flag rises only after the lockout command
  a_r6_lock_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(op) == OP_LOCK);

  // R8: identifier mode ends only on an exit command
  a_r8_exit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_mode) |-> $past(op) == OP_ID_OFF);

  // R7: read data is zero outside identifier mode
  a_r7_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !id_mode |-> id_data == '0);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic [1:0]        rd_sel,
  output logic              prog_start,
  output logic              chip_erase_start,
  output logic              sector_erase_start,
  output logic              lock_set,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic              id_mode,
  output logic              boot_locked,
  output logic [7:0]        id_data
);

  seq_st_t seq_state;
  op_t     issue_op;
  logic    wr_accept;

  flash_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .busy     (busy),
    .key_addr (wr_addr[CMP_W-1:0]),
    .wr_data  (wr_data),
    .state    (seq_state),
    .op       (issue_op),
    .accept   (wr_accept)
  );

  flash_op_issue #(.ADDR_W(ADDR_W)) u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (issue_op),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .prog_start (prog_start),
    .chip_start (chip_erase_start),
    .sect_start (sector_erase_start),
    .lock_start (lock_set),
    .op_addr    (op_addr),
    .op_data    (op_data)
  );

  flash_id_ctl #(.TOP_BOOT(TOP_BOOT)) u_id (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (issue_op),
    .rd_sel  (rd_sel),
    .id_mode (id_mode),
    .locked  (boot_locked),
    .id_data (id_data)
  );

  // R10: a write blocked by busy never yields a start pulse
  a_r10_busy_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> !(prog_start || chip_erase_start ||
                          sector_erase_start || lock_set));

  // R9: any start pulse follows an accepted write
  a_r9_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start || chip_erase_start || sector_erase_start || lock_set)
      |-> $past(wr_accept));

  // R7: identifier mode is entered only after an accepted write
  a_r7_entry_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> $past(wr_accept) && $past(seq_state) == ST_UNL2);

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [17:0] wr_addr;
  logic [7:0]  wr_data;
  logic        busy;
  logic [1:0]  rd_sel;
  logic        prog_start, chip_erase_start, sector_erase_start, lock_set;
  logic [17:0] op_addr;
  logic [7:0]  op_data;
  logic        id_mode, boot_locked;
  logic [7:0]  id_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .rd_sel(rd_sel),
    .prog_start(prog_start), .chip_erase_start(chip_erase_start),
    .sector_erase_start(sector_erase_start), .lock_set(lock_set),
    .op_addr(op_addr), .op_data(op_data), .id_mode(id_mode),
    .boot_locked(boot_locked), .id_data(id_data)
  );

  function automatic logic [3:0] pulses();
    return {prog_start, chip_erase_start, sector_erase_start, lock_set};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [17:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(18'h00555, 8'hAA);
    wr(18'h00AAA, 8'h55);
  endtask

  task automatic ext_prefix();
    unlock();
    wr(18'h00555, 8'h80);
    unlock();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 pulses", pulses(), 4'b0000);
    check("R1 id_mode", id_mode, 1'b0);
    check("R1 locked", boot_locked, 1'b0);
    check("R1 id_data", id_data, 8'h00);
  endtask

  task automatic t_program();
    unlock();
    wr(18'h00555, 8'hA0);
    wr(18'h31234, 8'h5A);
    check("R3 prog pulse", pulses(), 4'b1000);
    check("R3 op_addr", op_addr, 18'h31234);
    check("R3 op_data", op_data, 8'h5A);
    @(negedge clk);
    check("R11 pulse ends", pulses(), 4'b0000);
  endtask

  task automatic t_alias();
    wr(18'h3F555, 8'hAA);
    wr(18'h002AA, 8'h55);
    wr(18'h1D555, 8'hA0);
    wr(18'h00042, 8'hC3);
    check("R2 aliased keys", pulses(), 4'b1000);
    check("R2 op_data", op_data, 8'hC3);
  endtask

  task automatic t_chip();
    ext_prefix();
    wr(18'h00555, 8'h10);
    check("R4 chip pulse", pulses(), 4'b0100);
    @(negedge clk);
    check("R11 chip single", pulses(), 4'b0000);
  endtask

  task automatic t_sector();
    ext_prefix();
    wr(18'h21000, 8'h30);
    check("R5 sector pulse", pulses(), 4'b0010);
    check("R5 sector addr", op_addr, 18'h21000);
  endtask

  task automatic t_mismatch();
    wr(18'h00555, 8'hAA);
    wr(18'h00AAB, 8'h55);
    wr(18'h00555, 8'hA0);
    wr(18'h00100, 8'h11);
    check("R9 bad unlock addr", pulses(), 4'b0000);
    ext_prefix();
    wr(18'h00555, 8'h20);
    check("R9 bad sixth byte", pulses(), 4'b0000);
    wr(18'h00555, 8'h10);
    check("R9 no resume", pulses(), 4'b0000);
  endtask

  task automatic t_busy();
    busy = 1'b1;
    wr(18'h00555, 8'hAA);
    busy = 1'b0;
    wr(18'h00AAA, 8'h55);
    wr(18'h00555, 8'hA0);
    wr(18'h00100, 8'h22);
    check("R10 busy write dropped", pulses(), 4'b0000);
    unlock();
    busy = 1'b1;
    wr(18'h00999, 8'h77);
    busy = 1'b0;
    wr(18'h00555, 8'hA0);
    wr(18'h00777, 8'h3C);
    check("R10 position kept", pulses(), 4'b1000);
    check("R10 op_data", op_data, 8'h3C);
    ext_prefix();
    busy = 1'b1;
    wr(18'h00555, 8'h10);
    check("R10 busy sixth write", pulses(), 4'b0000);
    busy = 1'b0;
  endtask

  task automatic t_id_lock();
    wr(18'h00012, 8'hF0);
    check("R8 F0 outside id", id_mode, 1'b0);
    check("R8 F0 no pulse", pulses(), 4'b0000);
    unlock();
    wr(18'h00555, 8'h90);
    check("R7 id entry", id_mode, 1'b1);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] exp;
      rd_sel = i[1:0];
      #1;
      exp = (i == 0) ? 8'h1F : (i == 1) ? 8'h07 : (i == 2) ? 8'h00 : 8'h0F;
      check("R7 id value", id_data, exp);
    end
    rd_sel = 2'd2;
    ext_prefix();
    wr_addr = 18'h00555; wr_data = 8'h40; wr_en = 1'b1;
    #1;
    check("R7 lock read before edge", id_data, 8'h00);
    @(negedge clk);
    wr_en = 1'b0;
    check("R6 lock pulse", pulses(), 4'b0001);
    check("R6 locked", boot_locked, 1'b1);
    check("R7 lock read after edge", id_data, 8'h01);
    wr(18'h31234, 8'hF0);
    check("R8 single exit", id_mode, 1'b0);
    check("R7 data outside id", id_data, 8'h00);
    unlock();
    wr(18'h00555, 8'h90);
    check("R7 re-entry", id_mode, 1'b1);
    unlock();
    wr(18'h00555, 8'hF0);
    check("R8 full exit", id_mode, 1'b0);
    ext_prefix();
    wr(18'h00555, 8'h10);
    check("R6 sticky after erase", boot_locked, 1'b1);
    do_reset();
    check("R6 reset clears", boot_locked, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; busy = 1'b0; rd_sel = '0;
    @(negedge clk);
    do_reset();
    t_reset();
    t_program();
    t_alias();
    t_chip();
    t_sector();
    t_mismatch();
    t_busy();
    t_id_lock();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule